// File: doc/BRIEF.md
# Gaussian transmit pulse shaper

This block turns a one-bit transmit data stream into shaped frequency-deviation samples for a binary frequency-modulated transmitter. The data bit arrives from a foreign clock domain and is brought into the filter clock domain through a short synchronizer. It is taken once per symbol period and repeated at twelve samples per symbol. A fixed twelve-tap Gaussian impulse response with a bandwidth-time product of 0.5 then smooths every transition, so that the frequency swings gently from one extreme to the other.

The filtered value is expressed against a programmable full-scale level. A 3-bit deviation code then scales it from 60 % to 130 % of nominal in 10 % steps, and the result is clipped to the output word. With a 13.824 MHz filter clock the shaper serves a 1.152 Mbit/s symbol stream. In that case a full-scale output corresponds to the nominal ±350 kHz deviation. A shaping enable input selects between the Gaussian path and a plain rectangular level. The same scaling applies on both paths. An external DAC takes the signed sample whenever the valid strobe is high.

Top module: `gauss_tx_shaper`

## Requirements
- R1: While `rst_n` is low, `sample_out` is 0 and `sample_valid` is 0.
- R2: `sample_valid` rises once the sample line has filled after reset, which takes about TAPS filter clocks. It then stays high until the next reset.
- R3: The synchronized `tx_bit` is taken into the filter only once every SPS (12) clocks, on a free-running symbol phase. Output transitions that follow input changes held for at least SPS clocks therefore start a multiple of SPS clocks apart.
- R4: Tap k holds the sample that is k clocks old, with tap 0 the newest. The coefficients, from tap 0 to tap 11, are 122, 200, 298, 400, 488, 540, 540, 488, 400, 298, 200 and 122. They sum to 4096. A sample of 1 adds its coefficient and a sample of 0 subtracts it, giving acc. The shaped value is floor((acc*FULL_SCALE + 2048) / 4096). After a 0-to-1 symbol change, the output therefore steps through twelve consecutive per-clock values, one for each count of 1-samples in the line.
- R5: A long run of ones settles to +FULL_SCALE scaled by the code, and a long run of zeros settles to the exact negative of that value.
- R6: The scaled output is round(shaped*(6+code)/10), with halves rounded away from zero. So code 000 gives 60 %, 001 gives 70 %, and so on up to 111, which gives 130 %.
- R7: The output saturates symmetrically at ±(2^(OUT_W-1)-1). With FULL_SCALE 1700 and code 111, a run of ones gives 2047 and a run of zeros gives -2047.
- R8: With `shape_en` at 0, the shaped value is ±FULL_SCALE for the current bit (1 gives plus) and changes in a single step with no intermediate values. The deviation code still scales it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock, SPS times the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit | input | 1 | Transmit data bit, asynchronous to `clk` |
| shape_en | input | 1 | 1 selects Gaussian shaping, 0 selects the rectangular level |
| dev_code | input | 3 | Deviation scaling code, (6+code)×10 % |
| sample_out | output | OUT_W (12) | Signed shaped and scaled deviation sample |
| sample_valid | output | 1 | High while `sample_out` carries filter data |

## Verification
The bench records the step response after a symbol change and compares all twelve intermediate values with the coefficient table. A line that shifted in the wrong direction, a wrong coefficient or a wrong rounding offset would put a wrong value somewhere in that sequence. Every deviation code is swept with runs of both polarities, so truncating rounding or a gain that is off by one would show at once. The same sweep checks that the negative level is the exact mirror of the positive one and that code 111 clips at 2047 instead of wrapping. In bypass mode the bench checks that each output change is a single full-scale jump. It also checks that changes are spaced a multiple of twelve clocks apart, which a sampler that follows the input on every clock would break.

// File: rtl/gshape_pkg.sv
`timescale 1ns/1ps
package gshape_pkg;

   localparam int GS_TAPS      = 12;
   localparam int GS_COEF_FRAC = 12;

   // Half of a symmetric Gaussian (BT 0.5) sampled at 12 per symbol,
   // tap 0 is the newest sample; the full set sums to 2**GS_COEF_FRAC.
   function automatic int gs_coef(input int k);
      int m;
      m = (k < GS_TAPS / 2) ? k : (GS_TAPS - 1 - k);
      case (m)
         0:       return 122;
         1:       return 200;
         2:       return 298;
         3:       return 400;
         4:       return 488;
         5:       return 540;
         default: return 0;
      endcase
   endfunction

   function automatic int gs_coef_sum();
      int s;
      s = 0;
      for (int k = 0; k < GS_TAPS; k++) s += gs_coef(k);
      return s;
   endfunction

endpackage

// File: rtl/gshape_sampler.sv
`timescale 1ns/1ps
module gshape_sampler #(
   parameter int SPS         = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_bit,
   output logic cur_bit
);

   localparam int PH_W = (SPS > 1) ? $clog2(SPS) : 1;

   logic            bit_s;
   logic [PH_W-1:0] ph;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign bit_s = tx_bit;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= tx_bit;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign bit_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= '0;
         cur_bit <= 1'b0;
      end else begin
         ph <= (ph == PH_W'(SPS - 1)) ? '0 : ph + PH_W'(1);
         if (ph == '0) cur_bit <= bit_s;
      end
   end

   // R3
   ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph < PH_W'(SPS));

   // R3
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_bit != $past(cur_bit)) |-> ($past(ph) == '0));

endmodule

// File: rtl/gshape_fir.sv
`timescale 1ns/1ps
module gshape_fir
   import gshape_pkg::*;
#(
   parameter int TAPS       = 12,
   parameter int COEF_FRAC  = 12,
   parameter int FILT_W     = 13,
   parameter int FULL_SCALE = 1700
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cur_bit,
   input  logic                     shape_en,
   output logic signed [FILT_W-1:0] filt_q,
   output logic                     valid_f
);

   localparam int ACC_W  = COEF_FRAC + 2;
   localparam int MUL_W  = ACC_W + FILT_W;
   localparam int FILL_W = $clog2(TAPS + 1);
   localparam logic signed [FILT_W-1:0] FS_P = FILT_W'(FULL_SCALE);
   localparam logic signed [FILT_W-1:0] FS_N = -FILT_W'(FULL_SCALE);
   localparam logic signed [MUL_W-1:0]  FS_M = MUL_W'(FULL_SCALE);
   localparam logic signed [MUL_W-1:0]  HALF = MUL_W'(1 << (COEF_FRAC - 1));
   localparam logic signed [ACC_W-1:0]  ONE  = ACC_W'(1 << COEF_FRAC);

   logic [TAPS-1:0]          line;
   logic signed [ACC_W-1:0]  term [TAPS];
   logic signed [ACC_W-1:0]  acc;
   logic signed [MUL_W-1:0]  wide;
   logic signed [FILT_W-1:0] filt_n;
   logic [FILL_W-1:0]        fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= '0;
         fill <= '0;
      end else begin
         line <= {line[TAPS-2:0], cur_bit};
         if (fill != FILL_W'(TAPS)) fill <= fill + FILL_W'(1);
      end
   end

   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         localparam int C = gs_coef(k);
         assign term[k] = line[k] ? ACC_W'(C) : -ACC_W'(C);
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) acc = acc + term[k];
   end

   assign wide   = MUL_W'(acc) * FS_M + HALF;
   assign filt_n = FILT_W'(wide >>> COEF_FRAC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q  <= '0;
         valid_f <= 1'b0;
      end else begin
         filt_q  <= shape_en ? filt_n : (cur_bit ? FS_P : FS_N);
         valid_f <= (fill == FILL_W'(TAPS));
      end
   end

   // R4 R5
   unity_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line == '1) |-> (acc == ONE));

   // R4
   acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc <= ONE) && (acc >= -ONE));

   // R8
   bypass_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_f && !$past(shape_en)) |-> ((filt_q == FS_P) || (filt_q == FS_N)));

endmodule

// File: rtl/gshape_scaler.sv
`timescale 1ns/1ps
module gshape_scaler #(
   parameter int FILT_W = 13,
   parameter int OUT_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [FILT_W-1:0] filt_q,
   input  logic                     valid_f,
   input  logic [2:0]               dev_code,
   output logic signed [OUT_W-1:0]  out_q,
   output logic                     valid_q
);

   localparam int PROD_W = FILT_W + 5;
   localparam int MAXV   = (1 << (OUT_W - 1)) - 1;
   localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

   logic [3:0]               gain;
   logic signed [PROD_W-1:0] gain_s;
   logic signed [PROD_W-1:0] prod;
   logic                     neg;
   logic [PROD_W-1:0]        mag;
   logic [PROD_W-1:0]        quo;
   logic [PROD_W-1:0]        lim;
   logic signed [OUT_W-1:0]  sat_n;

   always_comb begin
      gain   = 4'd6 + {1'b0, dev_code};
      gain_s = PROD_W'(gain);
      prod   = PROD_W'(filt_q) * gain_s;
      neg    = prod[PROD_W-1];
      mag    = neg ? -prod : prod;
      quo    = (mag + PROD_W'(5)) / PROD_W'(10);
      lim    = (quo > PROD_W'(MAXV)) ? PROD_W'(MAXV) : quo;
      sat_n  = neg ? -OUT_W'(lim) : OUT_W'(lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         out_q   <= sat_n;
         valid_q <= valid_f;
      end
   end

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_q != MINV);

   // R6
   sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(filt_q) > 0) |-> (out_q > 0));

   // R2
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> valid_q);

endmodule

// File: rtl/gauss_tx_shaper.sv
`timescale 1ns/1ps
module gauss_tx_shaper
   import gshape_pkg::*;
#(
   parameter int SPS         = 12,
   parameter int TAPS        = 12,
   parameter int SYNC_STAGES = 2,
   parameter int OUT_W       = 12,
   parameter int FULL_SCALE  = 1700
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_bit,
   input  logic                    shape_en,
   input  logic [2:0]              dev_code,
   output logic signed [OUT_W-1:0] sample_out,
   output logic                    sample_valid
);

   localparam int FILT_W = OUT_W + 1;

   generate
      if (TAPS != GS_TAPS) begin : g_bad_taps
         $error("gauss_tx_shaper: TAPS must match the coefficient set");
      end
      if (gs_coef_sum() != (1 << GS_COEF_FRAC)) begin : g_bad_sum
         $error("gauss_tx_shaper: coefficients must sum to unity");
      end
      if (SPS < 2) begin : g_bad_sps
         $error("gauss_tx_shaper: SPS must be at least 2");
      end
      if (FULL_SCALE < 1 || FULL_SCALE >= (1 << OUT_W)) begin : g_bad_fs
         $error("gauss_tx_shaper: FULL_SCALE out of range");
      end
   endgenerate

   logic                     cur_bit;
   logic signed [FILT_W-1:0] filt_q;
   logic                     valid_f;

   gshape_sampler #(
      .SPS         (SPS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_bit  (tx_bit),
      .cur_bit (cur_bit)
   );

   gshape_fir #(
      .TAPS       (TAPS),
      .COEF_FRAC  (GS_COEF_FRAC),
      .FILT_W     (FILT_W),
      .FULL_SCALE (FULL_SCALE)
   ) u_fir (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_bit  (cur_bit),
      .shape_en (shape_en),
      .filt_q   (filt_q),
      .valid_f  (valid_f)
   );

   gshape_scaler #(
      .FILT_W (FILT_W),
      .OUT_W  (OUT_W)
   ) u_scaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .filt_q   (filt_q),
      .valid_f  (valid_f),
      .dev_code (dev_code),
      .out_q    (sample_out),
      .valid_q  (sample_valid)
   );

endmodule

// File: tb/gauss_tx_shaper_bench.sv
`timescale 1ns/1ps
module gauss_tx_shaper_bench;

   localparam int FS = 1700;
   localparam int NV = 16;
   localparam int VEC_CODE [NV] = '{0,0,1,1,2,2,3,3,4,4,5,5,6,6,7,7};
   localparam int VEC_BIT  [NV] = '{1,0,1,0,1,0,1,0,1,0,1,0,1,0,1,0};
   localparam int VEC_EXP  [NV] = '{1020,-1020,1190,-1190,1360,-1360,1530,-1530,
                                    1700,-1700,1870,-1870,2040,-2040,2047,-2047};
   localparam int COEF [12] = '{122,200,298,400,488,540,540,488,400,298,200,122};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_bit = 1'b0;
   logic        shape_en = 1'b1;
   logic [2:0]  dev_code = 3'd4;
   logic signed [11:0] sample_out;
   logic        sample_valid;

   int total = 0;
   int bad = 0;
   int drops = 0;
   bit seen_valid = 0;
   bit done = 0;
   int rec [100];

   gauss_tx_shaper u_gauss_tx_shaper (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_bit       (tx_bit),
      .shape_en     (shape_en),
      .dev_code     (dev_code),
      .sample_out   (sample_out),
      .sample_valid (sample_valid)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (seen_valid && !sample_valid) drops++;
         if (sample_valid) seen_valid = 1;
      end else begin
         seen_valid = 0;
      end
   end

   function automatic int shaped(input int acc);
      longint x;
      x = longint'(acc) * FS + 2048;
      return int'(x >>> 12);
   endfunction

   function automatic int scaled(input int f, input int code);
      int p, m, q;
      p = f * (6 + code);
      m = (p < 0) ? -p : p;
      q = (m + 5) / 10;
      if (q > 2047) q = 2047;
      return (p < 0) ? -q : q;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int first, nchg, acc, p;
      int chg_at [4];

      // R1: reset state
      repeat (5) @(negedge clk);
      check("R1 out", int'(sample_out), 0);
      check("R1 valid", int'(sample_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 early valid", int'(sample_valid), 0);
      repeat (30) @(negedge clk);
      check("R2 valid up", int'(sample_valid), 1);

      // R5 R6 R7: steady-run sweep over all codes, shaping on
      shape_en = 1'b1;
      for (int v = 0; v < NV; v++) begin
         dev_code = 3'(VEC_CODE[v]);
         tx_bit   = VEC_BIT[v][0];
         repeat (40) @(negedge clk);
         if (VEC_CODE[v] == 7)
            check("R7 saturate", int'(sample_out), VEC_EXP[v]);
         else if (VEC_CODE[v] == 4)
            check("R5 unity run", int'(sample_out), VEC_EXP[v]);
         else
            check("R6 code scale", int'(sample_out), VEC_EXP[v]);
      end

      // R4: step response through all twelve line states, code 4
      dev_code = 3'd4;
      tx_bit = 1'b0;
      repeat (40) @(negedge clk);
      tx_bit = 1'b1;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         rec[c] = int'(sample_out);
      end
      first = -1;
      for (int c = 0; c < 60; c++)
         if (first < 0 && rec[c] != -FS) first = c;
      check("R4 step seen", int'(first >= 0 && first < 40), 1);
      if (first >= 0 && first < 40) begin
         p = 0;
         for (int k = 1; k <= 12; k++) begin
            p += COEF[k-1];
            acc = 2 * p - 4096;
            check($sformatf("R4 step k=%0d", k), rec[first+k-1], scaled(shaped(acc), 4));
         end
         check("R4 settled", rec[first+12], FS);
      end

      // R6: rounding on a fractional product (code 1, mid-step values)
      dev_code = 3'd1;
      tx_bit = 1'b0;
      repeat (40) @(negedge clk);
      tx_bit = 1'b1;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         rec[c] = int'(sample_out);
      end
      first = -1;
      for (int c = 0; c < 60; c++)
         if (first < 0 && rec[c] != -1190) first = c;
      if (first >= 0 && first < 40) begin
         check("R6 round k=1", rec[first], scaled(shaped(-3852), 1));
         check("R6 round k=5", rec[first+4], scaled(shaped(-1080), 1));
         check("R6 round k=7", rec[first+6], scaled(shaped(1080), 1));
      end else begin
         check("R6 step seen", 0, 1);
      end

      // R8 R3: bypass single steps at symbol-aligned spacing
      shape_en = 1'b0;
      dev_code = 3'd4;
      tx_bit = 1'b0;
      repeat (40) @(negedge clk);
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         if (c == 5)  tx_bit = 1'b1;
         if (c == 22) tx_bit = 1'b0;
         if (c == 51) tx_bit = 1'b1;
         rec[c] = int'(sample_out);
      end
      nchg = 0;
      for (int c = 1; c < 100; c++) begin
         if (rec[c] != rec[c-1]) begin
            if (nchg < 4) chg_at[nchg] = c;
            nchg++;
         end
      end
      check("R3 change count", nchg, 3);
      if (nchg == 3) begin
         check("R3 spacing a", (chg_at[1] - chg_at[0]) % 12, 0);
         check("R3 spacing b", (chg_at[2] - chg_at[1]) % 12, 0);
      end
      p = 0;
      for (int c = 0; c < 100; c++)
         if (rec[c] != FS && rec[c] != -FS) p++;
      check("R8 no intermediate", p, 0);

      // R8: bypass still scaled
      dev_code = 3'd0;
      tx_bit = 1'b1;
      repeat (40) @(negedge clk);
      check("R8 scaled 60", int'(sample_out), 1020);
      dev_code = 3'd7;
      tx_bit = 1'b0;
      repeat (40) @(negedge clk);
      check("R8 scaled sat", int'(sample_out), -2047);

      // R2: valid never dropped; R1: reset again mid-run
      check("R2 valid held", drops, 0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset out", int'(sample_out), 0);
      check("R1 re-reset valid", int'(sample_valid), 0);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      check("R2 valid again", int'(sample_valid), 1);

      finish_run();
   end

endmodule